// File: doc/BRIEF.md
# Multi-tap serial audio delay chain

This block takes a single serial stereo stream (bit clock, word select, serial data) and produces several copies of it. Each copy feeds one of a set of identical stereo DACs whose output currents are summed off chip. Every copy is the input stream delayed by a whole number of bit-clock periods. The delays are spaced evenly across one stereo frame, so the summed DAC currents step between successive samples in several smaller increments. No faster clock and no digital interpolation are needed for this.

Word select and data pass through the same shift stages. Every copy is therefore a complete, valid frame aligned to the shared, unmultiplied bit clock, and each downstream DAC latches its own time-shifted copy of each sample. The chain samples on the rising bit-clock edge. Each tap is re-timed onto the falling edge, which gives the receivers half a period of margin on both sides. The number of taps, the frame length and the assignment of delay slots to output ports are parameters. A per-port valid flag tells the downstream logic when a tap carries real stream data rather than reset fill.

Top module: `audio_tap_fanout`

## Requirements
- R1: While `rst_ni` is low, every bit of `ws_o`, `sd_o` and `valid_o` is 0. Clearing is asynchronous and takes effect without waiting for a clock edge.
- R2: With NUM_TAPS taps and a frame of FRAME_LEN bit clocks, slot j has a delay of j*FRAME_LEN/NUM_TAPS cycles. With the defaults (64, 8) the delays are 0, 8, 16, 24, 32, 40, 48 and 56.
- R3: With 8 taps, ports 0..7 carry slots 0, 4, 2, 6, 1, 7, 3, 5. Ordered by increasing delay, the ports are therefore 0, 4, 2, 6, 1, 7, 3, 5.
- R4: Word select and data on a port carry the same delay. The pair sampled together on one rising edge leaves together on the port.
- R5: Input is sampled on the rising edge of `clk_i`. A port with delay d shows, after the falling edge that follows rising edge t, the input sampled at rising edge t-d. Outputs change only on falling edges.
- R6: Counting rising edges since reset release from 0, a port with delay d has `valid_o` low and outputs 0 up to rising edge d-1. From the falling edge after rising edge d onward, `valid_o` is high and stays high until the next reset.
- R7: Output ports with index NUM_TAPS or above drive 0 on `ws_o`, `sd_o` and `valid_o` at all times.
- R8: With NUM_TAPS = 4 and a slot map of 0, 2, 1, 3 on ports 0..3, the delays are 0, 32, 16 and 48 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Word select of the incoming stream |
| sd_i | input | 1 | Serial data of the incoming stream |
| ws_o | output | N_OUT | Delayed word select, one bit per DAC port |
| sd_o | output | N_OUT | Delayed serial data, one bit per DAC port |
| valid_o | output | N_OUT | Port carries stream data rather than reset fill |

## Verification
On a port's boundary cycle, its valid flag and its first real sample leave on the same falling edge, and a wrong count comparison shifts one against the other. The bench resets the chain before each stimulus pattern. It then compares every port against an independent history of the driven inputs on each cycle. This covers the edge where the deepest tap (56 cycles, or 48 in the four-tap instance) first turns valid, which is judged on both the flag and the data. A second overlap is an asynchronous reset that lands while a stream is running and the taps hold nonzero data. That reset is applied between edges, and all outputs are checked for zero before any clock edge follows.

// File: rtl/audio_tap_pkg.sv
package audio_tap_pkg;
  localparam int unsigned SLOT_W = 5;

  typedef struct packed {
    logic ws;
    logic sd;
  } lane_t;

  function automatic int unsigned tap_spacing(int unsigned frame_len, int unsigned taps);
    return frame_len / taps;
  endfunction
endpackage

// File: rtl/audio_delay_line.sv
module audio_delay_line #(
  parameter int unsigned DEPTH = 57
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  audio_tap_pkg::lane_t       in_i,
  output logic [DEPTH-1:0]           ws_q_o,
  output logic [DEPTH-1:0]           sd_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q_o <= '0;
      sd_q_o <= '0;
    end else begin
      ws_q_o[0] <= in_i.ws;
      sd_q_o[0] <= in_i.sd;
      for (int j = 1; j < int'(DEPTH); j++) begin
        ws_q_o[j] <= ws_q_o[j-1];
        sd_q_o[j] <= sd_q_o[j-1];
      end
    end
  end
endmodule

// File: rtl/audio_fill_counter.sv
module audio_fill_counter #(
  parameter int unsigned LIMIT = 57,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(LIMIT);

  // saturating count of rising edges since reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (cnt_o != CntMax) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/audio_tap_retimer.sv
module audio_tap_retimer #(
  parameter int unsigned DELAY = 0,
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  audio_tap_pkg::lane_t tap_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic                 ws_o,
  output logic                 sd_o,
  output logic                 valid_o
);
  logic filled;
  assign filled = (cnt_i > CNT_W'(DELAY));

  // falling-edge launch: half a period of margin at the receiver
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_o    <= 1'b0;
      sd_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      ws_o    <= filled & tap_i.ws;
      sd_o    <= filled & tap_i.sd;
      valid_o <= filled;
    end
  end
endmodule

// File: rtl/audio_tap_fanout.sv
module audio_tap_fanout #(
  parameter int unsigned FRAME_LEN = 64,
  parameter int unsigned NUM_TAPS  = 8,
  parameter int unsigned N_OUT     = 8,
  parameter logic [N_OUT-1:0][audio_tap_pkg::SLOT_W-1:0] SLOT_MAP =
    {5'd5, 5'd3, 5'd7, 5'd1, 5'd6, 5'd2, 5'd4, 5'd0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  input  logic             sd_i,
  output logic [N_OUT-1:0] ws_o,
  output logic [N_OUT-1:0] sd_o,
  output logic [N_OUT-1:0] valid_o
);
  import audio_tap_pkg::*;

  localparam int unsigned SPACING   = tap_spacing(FRAME_LEN, NUM_TAPS);
  localparam int unsigned MAX_DELAY = (NUM_TAPS - 1) * SPACING;
  localparam int unsigned DEPTH     = MAX_DELAY + 1;
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1);

  lane_t            in_lane;
  logic [DEPTH-1:0] ws_line;
  logic [DEPTH-1:0] sd_line;
  logic [CNT_W-1:0] fill_cnt;

  assign in_lane = '{ws: ws_i, sd: sd_i};

  audio_delay_line #(.DEPTH(DEPTH)) i_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_lane),
    .ws_q_o (ws_line),
    .sd_q_o (sd_line)
  );

  audio_fill_counter #(.LIMIT(DEPTH), .CNT_W(CNT_W)) i_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (fill_cnt)
  );

  for (genvar k = 0; k < int'(N_OUT); k++) begin : g_port
    if (k < int'(NUM_TAPS)) begin : g_tap
      localparam int unsigned DELAY = int'(SLOT_MAP[k]) * SPACING;
      lane_t tap;
      assign tap = '{ws: ws_line[DELAY], sd: sd_line[DELAY]};

      audio_tap_retimer #(.DELAY(DELAY), .CNT_W(CNT_W)) i_retime (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tap_i   (tap),
        .cnt_i   (fill_cnt),
        .ws_o    (ws_o[k]),
        .sd_o    (sd_o[k]),
        .valid_o (valid_o[k])
      );
    end else begin : g_unused
      assign ws_o[k]    = 1'b0;
      assign sd_o[k]    = 1'b0;
      assign valid_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/audio_tap_fanout_chk.sv
module audio_tap_fanout_chk #(
  parameter int unsigned NUM_TAPS = 8,
  parameter int unsigned N_OUT    = 8,
  parameter logic [N_OUT-1:0][audio_tap_pkg::SLOT_W-1:0] SLOT_MAP = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ws_i,
  input logic             sd_i,
  input logic [N_OUT-1:0] ws_o,
  input logic [N_OUT-1:0] sd_o,
  input logic [N_OUT-1:0] valid_o
);
  for (genvar k = 0; k < int'(NUM_TAPS); k++) begin : g_k
    // R6: once a tap turns valid it stays valid until reset
    a_r6_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[k] |=> valid_o[k]);

    if (SLOT_MAP[k] == 0) begin : g_zero
      // R5: zero-delay port shows the bit taken on the previous rising edge
      a_r5_tap0_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[k] |-> sd_o[k] == $past(sd_i));
      // R4: word select takes the same path as data
      a_r4_tap0_ws: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[k] |-> ws_o[k] == $past(ws_i));
    end

    for (genvar m = 0; m < int'(NUM_TAPS); m++) begin : g_m
      if (int'(SLOT_MAP[m]) == int'(SLOT_MAP[k]) + 1) begin : g_next
        // R2: a deeper slot never turns valid before the shallower one
        a_r2_valid_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
          valid_o[m] |-> valid_o[k]);
      end
    end
  end
endmodule

bind audio_tap_fanout audio_tap_fanout_chk #(
  .NUM_TAPS (NUM_TAPS),
  .N_OUT    (N_OUT),
  .SLOT_MAP (SLOT_MAP)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ws_i    (ws_i),
  .sd_i    (sd_i),
  .ws_o    (ws_o),
  .sd_o    (sd_o),
  .valid_o (valid_o)
);

// File: tb/test_audio_tap_fanout.sv
module test_audio_tap_fanout;
  localparam int N_OUT = 8;
  localparam int RUN   = 150;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ws_i = 1'b0;
  logic sd_i = 1'b0;
  logic [N_OUT-1:0] ws_a, sd_a, va_a;
  logic [N_OUT-1:0] ws_b, sd_b, va_b;

  always #4 clk_i = ~clk_i;

  audio_tap_fanout i_audio_tap_fanout (
    .clk_i, .rst_ni, .ws_i, .sd_i, .ws_o(ws_a), .sd_o(sd_a), .valid_o(va_a)
  );

  audio_tap_fanout #(
    .NUM_TAPS (4),
    .SLOT_MAP ({5'd0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd1, 5'd2, 5'd0})
  ) i_audio_tap_fanout_q (
    .clk_i, .rst_ni, .ws_i, .sd_i, .ws_o(ws_b), .sd_o(sd_b), .valid_o(va_b)
  );

  typedef struct packed {
    logic [1:0]  mode;   // 0 lfsr, 1 alternating, 2 all ones
    logic [15:0] seed;
    logic [5:0]  phase;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 16'hACE1, 6'd0},
    '{2'd1, 16'h0000, 6'd13},
    '{2'd2, 16'h0000, 6'd40},
    '{2'd0, 16'h5A3C, 6'd31}
  };

  int errs = 0;
  int checks = 0;
  logic hws [RUN];
  logic hsd [RUN];
  int slot8 [8] = '{0, 4, 2, 6, 1, 7, 3, 5};
  int slot4 [8] = '{0, 2, 1, 3, 0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_cfg(input int tp, input int ntaps, input int spacing,
                           input int slot [8], input logic [7:0] w,
                           input logic [7:0] s, input logic [7:0] v,
                           input string req);
    for (int k = 0; k < 8; k++) begin
      logic ew, es, ev;
      if (k >= ntaps) begin
        ew = 0; es = 0; ev = 0;
        chk({w[k], s[k], v[k]} == 3'b000, "R7", $sformatf("unused port %0d t=%0d", k, tp),
            {w[k], s[k], v[k]}, 0);
      end else begin
        int d = slot[k] * spacing;
        ev = (tp >= d);
        ew = ev ? hws[tp-d] : 1'b0;
        es = ev ? hsd[tp-d] : 1'b0;
        // R3 mapping / R4 ws lockstep / R5 edge timing / R6 valid fill
        chk({w[k], s[k], v[k]} == {ew, es, ev}, req,
            $sformatf("port %0d delay %0d t=%0d {ws,sd,valid}", k, d, tp),
            {w[k], s[k], v[k]}, {ew, es, ev});
      end
    end
  endtask

  task automatic check_all_zero(input string what);
    chk({ws_a, sd_a, va_a, ws_b, sd_b, va_b} == '0, "R1", what,
        int'(|{ws_a, sd_a, va_a, ws_b, sd_b, va_b}), 0);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #20;
    check_all_zero("outputs during power-on reset");

    foreach (VECS[i]) begin
      logic [15:0] lfsr = VECS[i].seed;
      for (int t = 0; t < RUN; t++) begin
        hws[t] = 1'(((t + int'(VECS[i].phase)) >> 5) & 1);
        case (VECS[i].mode)
          2'd0: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hsd[t] = lfsr[0];
          end
          2'd1: hsd[t] = 1'(t) ^ VECS[i].phase[0];
          default: hsd[t] = 1'b1;
        endcase
      end

      // async clear mid-stream, checked before any further edge (R1)
      @(negedge clk_i); #1;
      rst_ni = 1'b0;
      #1;
      check_all_zero($sformatf("async clear vector %0d", i));
      @(negedge clk_i); #1;
      rst_ni = 1'b1;

      for (int t = 0; t < RUN; t++) begin
        ws_i = hws[t];
        sd_i = hsd[t];
        @(posedge clk_i); #1;
        if (t == 0) check_all_zero("R6 nothing valid before first falling edge");
        else begin
          check_cfg(t - 1, 8, 8, slot8, ws_a, sd_a, va_a, "R2/R3/R4/R5/R6");
          check_cfg(t - 1, 4, 16, slot4, ws_b, sd_b, va_b, "R8");
        end
        @(negedge clk_i); #1;
      end
    end

    // directed: hold reset across edges, outputs stay clear (R1)
    rst_ni = 1'b0;
    ws_i = 1'b1; sd_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check_all_zero("reset held across edges");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule